// File: doc/BRIEF.md
# Grouped-Enable Dual-Rail Pipeline Column

This block is a clocked model of a multi-stage pipeline that carries dual-rail data. Every bit of every stage is a small buffer process. It takes a token from the previous column through a four-phase return-to-zero handshake, holds it, and offers it to the next column. The buffer computes nothing: each bit passes its token through unchanged. Handshake wires are registered and sampled on the clock edge, so every transition takes one cycle.

A bit does not empty itself on its own acknowledge alone. The release that bit i sees comes from a dedicated C-element. That C-element watches the acknowledges of bits i-1, i and i+1 in the following column. A bit therefore stays full until the slowest of its neighbours downstream has taken its token. If a wrong rail fires early, the correct rail still has time to rise and turn the pair into a visible illegal code. If a token vanishes, the neighbourhood stalls for good instead of drifting out of step. The bits are split into partitions of a set size. Neighbourhoods never cross a partition boundary, so a stall stays inside the partition where it happened.

Top module: `grp_dr_pipe`

## Requirements
- R1: Each bit is a rail pair written {true,false}: 00 is neutral (no token), 10 carries a one, 01 carries a zero and 11 is illegal. A token that enters on bit i leaves on bit i with the same code.
- R2: During and right after reset, every output pair is 00 and every input enable is 1.
- R3: The input enable of bit i falls only after that bit has taken a token. It rises again only after the input pair has returned to 00 and the bit has emptied.
- R4: Each grouped release is a C-element that resets to 0. It goes to 1 when all of its acknowledge inputs are 1 and to 0 when all of them are 0. Otherwise it keeps its value.
- R5: The acknowledge inputs of bit i are bits i-1, i and i+1 of the next column, limited to the partition of PART consecutive bits that holds bit i. An edge bit of a partition uses two inputs. Partitions do not affect each other.
- R6: A full bit keeps its token until every acknowledge in its neighbourhood has fallen.
- R7: A full bit is never overwritten by another token. It takes a new token only after it has returned to 00 with its release and its input enable both high.
- R8: If one bit of a word never receives its token, its neighbours in the same partition stay full and their input enables stay 0 for good. No further token passes them, while other partitions keep flowing.
- R9: An illegal 11 code is carried to the output like any token. It is not masked or corrected.
- R10: In an idle pipeline with a ready sink, a word driven on the inputs appears on the outputs STAGES clock edges later. Words leave in the order they entered, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all handshake state |
| rst_n | input | 1 | Synchronous active-low reset |
| in_t | input | WIDTH | True rails of the incoming word |
| in_f | input | WIDTH | False rails of the incoming word |
| in_en | output | WIDTH | Per-bit enable to the source: 1 means ready, 0 means token taken |
| out_t | output | WIDTH | True rails of the outgoing word |
| out_f | output | WIDTH | False rails of the outgoing word |
| out_en | input | WIDTH | Per-bit enable from the sink: 1 means ready, 0 means token taken |

## Verification
A bit stuck full or a C-element stuck at the wrong level shows at the ports within a few edges. An input enable stays low, or an output pair does not return to 00 after the sink has acknowledged. A release that falls too early shows as an output pair that goes neutral while a neighbouring sink enable is still high. An overwrite or a lost release shows as a changed or missing token in the per-bit sequence the sink collects. The bench tracks every enable and rail against its own model on every edge, so any divergence is caught on the cycle it first reaches a port.

// File: rtl/grp_dr_pkg.sv
// Shared types for the grouped-enable dual-rail pipeline.
// A rail pair is packed {true, false}; 00 means no token.
package grp_dr_pkg;
    typedef logic [1:0] rail_t;
    localparam rail_t RAIL_NULL = 2'b00;

    // True when the pair carries any token, legal or not.
    function automatic logic has_token(input rail_t v);
        return v != RAIL_NULL;
    endfunction
endpackage

// File: rtl/grp_dr_celem.sv
// Clocked N-input C-element.
// Output rises when every input is high, falls when every input is low,
// and otherwise keeps its value. Resets low. Assumes N >= 1.
module grp_dr_celem #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic         dout
);
    // Purpose: update the agreement state from the sampled inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)      dout <= 1'b0;
        else if (&din)   dout <= 1'b1;
        else if (~|din)  dout <= 1'b0;
    end

    // R4: a rise needs all inputs high on the previous edge
    a_r4_rise_all_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout) |-> $past(&din));
    // R4: a fall needs all inputs low on the previous edge
    a_r4_fall_all_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dout) |-> $past(~|din));
endmodule

// File: rtl/grp_dr_cell.sv
// One bit-process: a dual-rail buffer with a four-phase input handshake.
// It takes a token when empty, enabled and released. It empties when the
// grouped release from the next column falls. The enable drops once the
// token is held and rises once both the input and the buffer are neutral.
// Assumes the release input comes from a C-element over the next column.
module grp_dr_cell
    import grp_dr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  rail_t x,
    input  logic  rel,
    output rail_t r,
    output logic  en
);
    // Purpose: hold, take or drop the token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r <= RAIL_NULL;
        end else if (!has_token(r)) begin
            if (en && rel && has_token(x)) r <= x;
        end else if (!rel) begin
            r <= RAIL_NULL;
        end
    end

    // Purpose: four-phase enable toward the previous column.
    always_ff @(posedge clk) begin
        if (!rst_n)                              en <= 1'b1;
        else if (has_token(r) && has_token(x))   en <= 1'b0;
        else if (!has_token(r) && !has_token(x)) en <= 1'b1;
    end

    // R7: a held token never changes into another token
    a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        has_token(r) |=> (r == $past(r) || r == RAIL_NULL));
    // R7: a token is taken only while enabled and released
    a_r7_take_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (has_token(r) && !has_token($past(r))) |-> $past(en && rel));
    // R6: the buffer empties only after the grouped release has fallen
    a_r6_empty_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!has_token(r) && has_token($past(r))) |-> !$past(rel));
    // R3: the enable falls only while a token is held
    a_r3_enable_falls_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> $past(has_token(r)));
    // R3: the enable rises only after the input went neutral
    a_r3_enable_rises_neutral: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> $past(!has_token(x)));
endmodule

// File: rtl/grp_dr_stage.sv
// One column of WIDTH bit-processes. For every bit, a C-element groups the
// acknowledges of the bit and its neighbours in the next column, limited to
// the bit's partition of PART consecutive bits. Edge bits of a partition
// therefore group two acknowledges, and PART = 1 degenerates to one.
module grp_dr_stage #(
    parameter int WIDTH = 8,
    parameter int PART  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] x_t,
    input  logic [WIDTH-1:0] x_f,
    output logic [WIDTH-1:0] x_en,
    output logic [WIDTH-1:0] y_t,
    output logic [WIDTH-1:0] y_f,
    input  logic [WIDTH-1:0] y_en
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam int BASE = (i / PART) * PART;
        localparam int LAST = (BASE + PART - 1 < WIDTH - 1) ? BASE + PART - 1 : WIDTH - 1;
        localparam int LO   = (i - 1 < BASE) ? BASE : i - 1;
        localparam int HI   = (i + 1 > LAST) ? LAST : i + 1;
        localparam int NIN  = HI - LO + 1;

        logic              rel;
        grp_dr_pkg::rail_t held;

        grp_dr_celem #(.N(NIN)) u_grp (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (y_en[HI:LO]),
            .dout (rel)
        );

        grp_dr_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .x    ({x_t[i], x_f[i]}),
            .rel  (rel),
            .r    (held),
            .en   (x_en[i])
        );

        assign y_t[i] = held[1];
        assign y_f[i] = held[0];
    end
endmodule

// File: rtl/grp_dr_pipe.sv
// Grouped-enable dual-rail pipeline: STAGES columns of WIDTH bits chained
// through per-bit rails and enables. The sink's enables act as the
// acknowledges of a virtual column after the last one. Assumes the source
// and sink follow the four-phase return-to-zero handshake per bit.
module grp_dr_pipe #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 3,
    parameter int PART   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_t,
    input  logic [WIDTH-1:0] in_f,
    output logic [WIDTH-1:0] in_en,
    output logic [WIDTH-1:0] out_t,
    output logic [WIDTH-1:0] out_f,
    input  logic [WIDTH-1:0] out_en
);
    logic [WIDTH-1:0] col_t  [STAGES+1];
    logic [WIDTH-1:0] col_f  [STAGES+1];
    logic [WIDTH-1:0] col_en [STAGES+1];

    assign col_t[0]       = in_t;
    assign col_f[0]       = in_f;
    assign in_en          = col_en[0];
    assign col_en[STAGES] = out_en;
    assign out_t          = col_t[STAGES];
    assign out_f          = col_f[STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_col
        grp_dr_stage #(.WIDTH(WIDTH), .PART(PART)) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .x_t  (col_t[s]),
            .x_f  (col_f[s]),
            .x_en (col_en[s]),
            .y_t  (col_t[s+1]),
            .y_f  (col_f[s+1]),
            .y_en (col_en[s+1])
        );
    end
endmodule

// File: tb/sim_grp_dr_pipe.sv
// Bench: behavioural per-bit model compared on every edge, plus directed
// scenarios for latency, slow sink, illegal code and lost token.
module sim_grp_dr_pipe;
    localparam int W = 6;
    localparam int S = 3;
    localparam int P = 3;
    localparam int CLK_NS = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] in_t = '0;
    logic [W-1:0] in_f = '0;
    logic [W-1:0] out_en = '1;
    logic [W-1:0] in_en, out_t, out_f;

    always #(CLK_NS/2) clk = ~clk;

    grp_dr_pipe #(.WIDTH(W), .STAGES(S), .PART(P)) u0 (
        .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f), .in_en(in_en),
        .out_t(out_t), .out_f(out_f), .out_en(out_en)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_r [S][W];
    bit m_e [S][W];
    bit m_g [S][W];
    bit model_on = 1'b0;

    task automatic model_step();
        int nr [S][W];
        bit ne [S][W];
        bit ng [S][W];
        for (int s = 0; s < S; s++) begin
            for (int i = 0; i < W; i++) begin
                int x, base, last, lo, hi;
                bit all1, all0, a;
                if (!rst_n) begin
                    nr[s][i] = 0; ne[s][i] = 1'b1; ng[s][i] = 1'b0;
                end else begin
                    x    = (s == 0) ? int'({in_t[i], in_f[i]}) : m_r[s-1][i];
                    base = (i / P) * P;
                    last = (base + P - 1 < W - 1) ? base + P - 1 : W - 1;
                    lo   = (i - 1 < base) ? base : i - 1;
                    hi   = (i + 1 > last) ? last : i + 1;
                    all1 = 1'b1; all0 = 1'b1;
                    for (int j = lo; j <= hi; j++) begin
                        a = (s == S - 1) ? out_en[j] : m_e[s+1][j];
                        if (a) all0 = 1'b0; else all1 = 1'b0;
                    end
                    ng[s][i] = all1 ? 1'b1 : (all0 ? 1'b0 : m_g[s][i]);
                    if (m_r[s][i] == 0)
                        nr[s][i] = (m_e[s][i] && m_g[s][i] && x != 0) ? x : 0;
                    else
                        nr[s][i] = m_g[s][i] ? m_r[s][i] : 0;
                    if (m_r[s][i] != 0 && x != 0)      ne[s][i] = 1'b0;
                    else if (m_r[s][i] == 0 && x == 0) ne[s][i] = 1'b1;
                    else                               ne[s][i] = m_e[s][i];
                end
            end
        end
        m_r = nr; m_e = ne; m_g = ng;
    endtask

    always @(posedge clk) model_step();

    // Compare every port against the model away from the active edge (R3/R4).
    always @(negedge clk) begin
        logic [W-1:0] et, ef, ee;
        if (model_on && rst_n) begin
            for (int i = 0; i < W; i++) begin
                et[i] = m_r[S-1][i][1];
                ef[i] = m_r[S-1][i][0];
                ee[i] = m_e[0][i];
            end
            chk({out_t, out_f, in_en} == {et, ef, ee}, "R3/R4", "model {t,f,en}",
                {out_t, out_f, in_en}, {et, ef, ee});
        end
    end

    // ---------------- sink ----------------
    bit hold [W];
    logic [1:0] rx [W][$];

    always @(negedge clk) begin
        logic [1:0] v;
        if (!rst_n) begin
            out_en = '1;
        end else begin
            for (int i = 0; i < W; i++) begin
                v = {out_t[i], out_f[i]};
                if (v != 2'b00 && out_en[i] && !hold[i]) begin
                    rx[i].push_back(v);
                    out_en[i] = 1'b0;
                end else if (v == 2'b00 && !out_en[i]) begin
                    out_en[i] = 1'b1;
                end
            end
        end
    end

    task automatic clear_rx();
        for (int i = 0; i < W; i++) rx[i].delete();
    endtask

    task automatic wait_en(input logic [W-1:0] mask, input bit lvl, input string req);
        logic [W-1:0] want;
        want = lvl ? mask : '0;
        for (int k = 0; k < 200; k++) begin
            if ((in_en & mask) == want) break;
            @(negedge clk);
        end
        chk((in_en & mask) == want, req, "input enable", in_en & mask, want);
    endtask

    task automatic drive(input logic [W-1:0] v, input logic [W-1:0] ill,
                         input logic [W-1:0] drop);
        for (int i = 0; i < W; i++) begin
            in_t[i] = !drop[i] && (ill[i] || v[i]);
            in_f[i] = !drop[i] && (ill[i] || !v[i]);
        end
    endtask

    task automatic send_word(input logic [W-1:0] v, input logic [W-1:0] ill,
                             input logic [W-1:0] drop, input string req);
        @(negedge clk);
        drive(v, ill, drop);
        wait_en(~drop, 1'b0, req);
        @(negedge clk);
        in_t = '0; in_f = '0;
        wait_en(~drop, 1'b1, req);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    logic [W-1:0] words [5] = '{6'h15, 6'h2A, 6'h3F, 6'h00, 6'h09};
    localparam logic [W-1:0] WA = 6'b110101;
    localparam logic [W-1:0] WB = 6'b001010;

    initial begin
        for (int i = 0; i < W; i++) hold[i] = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_t == '0 && out_f == '0, "R2", "outputs in reset", {out_t, out_f}, 0);
        chk(in_en == '1, "R2", "enables in reset", in_en, {W{1'b1}});
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);
        chk(out_t == '0 && out_f == '0 && in_en == '1, "R2", "state after reset",
            {out_t, out_f, in_en}, {W{1'b1}});
        idle(3);

        // R10 latency: STAGES edges from input to output.
        clear_rx();
        drive(6'b101100, '0, '0);
        repeat (S - 1) @(posedge clk);
        @(negedge clk);
        chk(out_t == '0 && out_f == '0, "R10", "output before latency", {out_t, out_f}, 0);
        @(posedge clk);
        @(negedge clk);
        chk(out_t == 6'b101100 && out_f == 6'b010011, "R10", "output at latency (R1 code)",
            {out_t, out_f}, {6'b101100, 6'b010011});
        wait_en('1, 1'b0, "R3");
        @(negedge clk);
        in_t = '0; in_f = '0;
        wait_en('1, 1'b1, "R3");
        idle(10);

        // R1 and R10: stream of words, order kept per bit.
        clear_rx();
        foreach (words[k]) send_word(words[k], '0, '0, "R3");
        idle(20);
        for (int i = 0; i < W; i++) begin
            chk(rx[i].size() == 5, "R10", $sformatf("token count bit %0d", i), rx[i].size(), 5);
            if (rx[i].size() == 5)
                for (int k = 0; k < 5; k++)
                    chk(rx[i][k] == (words[k][i] ? 2'b10 : 2'b01), "R1",
                        $sformatf("bit %0d token %0d", i, k), rx[i][k],
                        words[k][i] ? 2'b10 : 2'b01);
        end

        // R6/R4/R5: sink holds bit 1; its neighbours stay full, other partition flows.
        clear_rx();
        hold[1] = 1'b1;
        send_word(WA, '0, '0, "R5");
        idle(30);
        chk({out_t[0], out_f[0], out_t[2], out_f[2]} == 4'b1010, "R6",
            "neighbours held full", {out_t[0], out_f[0], out_t[2], out_f[2]}, 4'b1010);
        chk({out_t[1], out_f[1]} == 2'b01, "R4", "held bit output", {out_t[1], out_f[1]}, 2'b01);
        chk(out_t[5:3] == 0 && out_f[5:3] == 0, "R5", "other partition drained",
            {out_t[5:3], out_f[5:3]}, 0);
        chk(rx[3].size() == 1 && rx[1].size() == 0, "R5", "tokens received bits 3/1",
            {rx[3].size(), rx[1].size()}, {32'd1, 32'd0});
        @(negedge clk);
        drive(WB, '0, '0);
        idle(12);
        chk({out_t[2:0], out_f[2:0]} == {WA[2:0], ~WA[2:0]}, "R7", "no overwrite while full",
            {out_t[2:0], out_f[2:0]}, {WA[2:0], ~WA[2:0]});
        chk(rx[4].size() == 2, "R5", "partition 1 accepted second word", rx[4].size(), 2);
        in_t = '0; in_f = '0;
        idle(4);
        hold[1] = 1'b0;
        idle(60);
        for (int i = 0; i < W; i++) begin
            chk(rx[i].size() == 2, "R10", $sformatf("bit %0d count after release", i),
                rx[i].size(), 2);
            if (rx[i].size() == 2) begin
                chk(rx[i][0] == (WA[i] ? 2'b10 : 2'b01), "R1", $sformatf("bit %0d first", i),
                    rx[i][0], WA[i] ? 2'b10 : 2'b01);
                chk(rx[i][1] == (WB[i] ? 2'b10 : 2'b01), "R1", $sformatf("bit %0d second", i),
                    rx[i][1], WB[i] ? 2'b10 : 2'b01);
            end
        end
        chk(in_en == '1, "R3", "all enables back high", in_en, {W{1'b1}});

        // R9: illegal code on bit 2 is carried through, then a legal word follows.
        clear_rx();
        send_word('0, 6'b000100, '0, "R9");
        idle(20);
        send_word('1, '0, '0, "R9");
        idle(20);
        chk(rx[2].size() == 2 && rx[2][0] == 2'b11, "R9", "illegal code at output",
            rx[2].size() > 0 ? rx[2][0] : 0, 2'b11);
        chk(rx[2].size() == 2 && rx[2][1] == 2'b10, "R9", "next token on bit 2",
            rx[2].size() > 1 ? rx[2][1] : 0, 2'b10);
        chk(rx[0].size() == 2 && rx[0][0] == 2'b01, "R1", "zero on bit 0",
            rx[0].size() > 0 ? rx[0][0] : 0, 2'b01);

        // R8: bit 4 token lost; neighbours 3 and 5 stall, partition 0 flows.
        clear_rx();
        @(negedge clk);
        drive('1, '0, 6'b010000);
        idle(12);
        in_t = '0; in_f = '0;
        idle(40);
        chk(in_en[3] == 1'b0 && in_en[5] == 1'b0, "R8", "neighbour enables stuck low",
            {in_en[5], in_en[3]}, 0);
        chk({out_t[3], out_f[3]} == 2'b10, "R8", "bit 3 output stuck full",
            {out_t[3], out_f[3]}, 2'b10);
        drive('0, '0, 6'b010000);
        idle(12);
        in_t = '0; in_f = '0;
        idle(40);
        chk(rx[0].size() == 2, "R8", "partition 0 still flows", rx[0].size(), 2);
        chk(rx[3].size() == 1 && rx[5].size() == 1, "R8", "no further token on 3/5",
            {rx[3].size(), rx[5].size()}, {32'd1, 32'd1});
        chk(in_en[3] == 1'b0, "R8", "stall is permanent", in_en[3], 0);

        // Reset clears the stall.
        model_on = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_t == '0 && out_f == '0 && in_en == '1, "R2", "state after second reset",
            {out_t, out_f, in_en}, {W{1'b1}});
        finish_run();
    end
endmodule